// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block converts single read or write requests from an on-chip host into timed cycles on an asynchronous memory bus of the kind used by SRAM, NOR flash and NAND flash parts. The host address carries a chip-select number in its top bits and an offset below them. Each of the chip selects owns a window of 2^OFS_W bytes, which is 64 MiB with the defaults, so 256 MiB can be addressed over the four selects. Every cycle on the memory bus has three timed phases: setup, strobe and hold. The read and write lengths of each phase are set separately for each chip select and are counted in controller clocks.

Each chip select has its own configuration, supplied on static input vectors: the six phase widths, a turnaround gap, a data width of 8 or 16 bits, a mode in which the chip select itself acts as the strobe, and a mode in which a per-select wait input stretches the strobe phase. Read data is returned to the host as a one-cycle valid pulse.

The controller is a five-state machine. IDLE accepts a request. TURN inserts the turnaround gap. SETUP, STROBE and HOLD time the access. The transitions are: IDLE to TURN (a gap is needed), IDLE to SETUP (no gap), TURN to SETUP (gap expired), SETUP to STROBE (setup expired), STROBE to STROBE (wait extension), STROBE to HOLD (strobe expired, wait low), and HOLD to IDLE (hold expired).

Top module: `async_mem_ctrl`

## Requirements
- R1: The two top request address bits pick the chip select. During an access only the `mem_cs_n` bit of that select is low, and no more than one bit is ever low.
- R2: A read lasts max(1,rd_setup) SETUP cycles, then max(1,rd_strobe) STROBE cycles with `mem_oe_n` low, then max(1,rd_hold) HOLD cycles. `mem_cs_n` is low over all three phases and `mem_we_n` stays high.
- R3: A write uses the write widths in the same way, with `mem_we_n` low only in STROBE. From the first setup cycle to the last hold cycle, `mem_dq` carries the write data and `mem_addr` does not change.
- R4: A width field of 0 gives the same timing as a field of 1.
- R5: If the previous access used a different chip select or the other direction, and that select's 3-bit turnaround field T is nonzero, exactly T TURN cycles follow the accept cycle. All strobes are high and `req_ready` is low during them. Idle cycles before the accept are not counted against T.
- R6: A read after a read, or a write after a write, to the same chip select starts SETUP in the cycle after the accept cycle, with no TURN cycles.
- R7: With select-strobe mode set for a chip select, that select's `mem_cs_n` is low only in STROBE cycles.
- R8: With extended-wait mode set, STROBE continues past its programmed length for as long as `mem_wait` of the active select is high at the end of a strobe cycle. With the mode clear, the wait input has no effect on timing.
- R9: A cleared width bit selects 8 bits. Then `mem_addr` is the byte offset, `mem_be_n` is 2'b10, writes drive {8'h00, wdata[7:0]} and reads return {8'h00, dq[7:0]}. A set bit selects 16 bits. Then `mem_addr` is the offset shifted right by one, and `mem_be_n` is ~be on writes and 2'b00 on reads.
- R10: Read data is sampled from `mem_dq` at the end of the last STROBE cycle. It is returned on `rsp_rdata` with `rsp_valid` high for exactly the one cycle after the last HOLD cycle.
- R11: During and after reset, all `mem_cs_n` bits, `mem_oe_n` and `mem_we_n` are high, `rsp_valid` is low and `req_ready` is high.
- R12: `req_ready` is high only in IDLE. A request is taken in a cycle where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | CSW+OFS_W | Chip-select number (top bits) and byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for 16-bit writes |
| rsp_valid | output | 1 | One-cycle read-data-valid pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_rd_setup | input | NCS*4 | Read setup width for each select |
| cfg_rd_strobe | input | NCS*4 | Read strobe width for each select |
| cfg_rd_hold | input | NCS*4 | Read hold width for each select |
| cfg_wr_setup | input | NCS*4 | Write setup width for each select |
| cfg_wr_strobe | input | NCS*4 | Write strobe width for each select |
| cfg_wr_hold | input | NCS*4 | Write hold width for each select |
| cfg_turn | input | NCS*3 | Turnaround gap for each select |
| cfg_wide | input | NCS | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_sel_strobe | input | NCS | Chip select acts as strobe |
| cfg_ext_wait | input | NCS | Wait input stretches strobe |
| mem_cs_n | output | NCS | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | OFS_W | Memory address |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_dq | inout | 16 | Bidirectional data bus |
| mem_wait | input | NCS | Wait request for each select, active high |

## Verification
The final HOLD cycle of a read is followed by the IDLE cycle that carries its `rsp_valid` pulse. That same IDLE cycle is also the earliest cycle in which the next request can be accepted. The bench keeps `req_valid` asserted for back-to-back traffic, so the read-data return and the acceptance of the next access fall in that one cycle. Several of these back-to-back pairs also change direction or chip select, which makes TURN cycles follow the pulse. In every such cycle the reference model checks the pulse, the returned data, `req_ready`, and the start of the next phase sequence on the following clocks.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int TIME_W = 4;
    localparam int GAP_W  = 3;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } phase_e;

    // phase lengths held as (cycles - 1) after clamping zero to one
    typedef struct packed {
        logic [TIME_W-1:0] rd_su;
        logic [TIME_W-1:0] rd_st;
        logic [TIME_W-1:0] rd_ho;
        logic [TIME_W-1:0] wr_su;
        logic [TIME_W-1:0] wr_st;
        logic [TIME_W-1:0] wr_ho;
        logic              wide;
        logic              ss;
        logic              ew;
    } cs_cfg_t;

    function automatic logic [TIME_W-1:0] len_m1(input logic [TIME_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

endpackage

// File: rtl/amc_cfg_mux.sv
module amc_cfg_mux #(
    parameter int NCS = 4
) (
    input  logic [NCS*amc_pkg::TIME_W-1:0] rd_setup,
    input  logic [NCS*amc_pkg::TIME_W-1:0] rd_strobe,
    input  logic [NCS*amc_pkg::TIME_W-1:0] rd_hold,
    input  logic [NCS*amc_pkg::TIME_W-1:0] wr_setup,
    input  logic [NCS*amc_pkg::TIME_W-1:0] wr_strobe,
    input  logic [NCS*amc_pkg::TIME_W-1:0] wr_hold,
    input  logic [NCS-1:0]                 wide,
    input  logic [NCS-1:0]                 ss_mode,
    input  logic [NCS-1:0]                 ew_mode,
    input  logic [$clog2(NCS)-1:0]         sel,
    output amc_pkg::cs_cfg_t               cfg
);
    localparam int TW = amc_pkg::TIME_W;

    amc_pkg::cs_cfg_t tbl [NCS];

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            amc_pkg::cs_cfg_t ent;
            assign ent.rd_su = amc_pkg::len_m1(rd_setup [i*TW +: TW]);
            assign ent.rd_st = amc_pkg::len_m1(rd_strobe[i*TW +: TW]);
            assign ent.rd_ho = amc_pkg::len_m1(rd_hold  [i*TW +: TW]);
            assign ent.wr_su = amc_pkg::len_m1(wr_setup [i*TW +: TW]);
            assign ent.wr_st = amc_pkg::len_m1(wr_strobe[i*TW +: TW]);
            assign ent.wr_ho = amc_pkg::len_m1(wr_hold  [i*TW +: TW]);
            assign ent.wide  = wide[i];
            assign ent.ss    = ss_mode[i];
            assign ent.ew    = ew_mode[i];
            assign tbl[i]    = ent;
        end
    endgenerate

    assign cfg = tbl[sel];

endmodule

// File: rtl/amc_fsm.sv
module amc_fsm #(
    parameter int NCS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [$clog2(NCS)-1:0]         req_cs,
    input  amc_pkg::cs_cfg_t               cfg,
    input  logic [NCS*amc_pkg::GAP_W-1:0]  turn,
    input  logic [NCS-1:0]                 mem_wait,
    output logic                           req_ready,
    output logic                           accept,
    output logic                           active,
    output logic                           capture,
    output logic                           rvalid,
    output logic                           act_wr,
    output logic [$clog2(NCS)-1:0]         act_cs,
    output logic [NCS-1:0]                 cs_n,
    output logic                           oe_n,
    output logic                           we_n
);
    import amc_pkg::*;

    localparam int TW  = TIME_W;
    localparam int GW  = GAP_W;
    localparam int CSW = $clog2(NCS);

    phase_e          state, state_nxt;
    logic [TW-1:0]   cnt, cnt_nxt;
    logic            have_prev;
    logic            rv_nxt;
    logic            dir;
    logic [TW-1:0]   su_m1, st_m1, ho_m1;
    logic [GW-1:0]   last_gap;
    logic            need_turn;
    logic            wait_hit;

    // phase lengths of the direction in flight (request direction while idle)
    always_comb begin
        dir      = (state == ST_IDLE) ? req_write : act_wr;
        su_m1    = dir ? cfg.wr_su : cfg.rd_su;
        st_m1    = dir ? cfg.wr_st : cfg.rd_st;
        ho_m1    = dir ? cfg.wr_ho : cfg.rd_ho;
        last_gap = turn[int'(act_cs)*GW +: GW];
        need_turn = have_prev && ((req_cs != act_cs) || (req_write != act_wr))
                    && (last_gap != '0);
        wait_hit = cfg.ew && mem_wait[act_cs];
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        accept    = 1'b0;
        capture   = 1'b0;
        rv_nxt    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (need_turn) begin
                        state_nxt = ST_TURN;
                        cnt_nxt   = {{(TW-GW){1'b0}}, last_gap} - 1'b1;
                    end else begin
                        state_nxt = ST_SETUP;
                        cnt_nxt   = su_m1;
                    end
                end
            end
            ST_TURN: begin
                if (cnt == '0) begin
                    state_nxt = ST_SETUP;
                    cnt_nxt   = su_m1;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_nxt = ST_STROBE;
                    cnt_nxt   = st_m1;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - 1'b1;
                end else if (!wait_hit) begin
                    capture   = !act_wr;
                    state_nxt = ST_HOLD;
                    cnt_nxt   = ho_m1;
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    state_nxt = ST_IDLE;
                    rv_nxt    = !act_wr;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rvalid    <= 1'b0;
            act_cs    <= '0;
            act_wr    <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            state  <= state_nxt;
            cnt    <= cnt_nxt;
            rvalid <= rv_nxt;
            if (accept) begin
                act_cs    <= req_cs;
                act_wr    <= req_write;
                have_prev <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        active    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        cs_n      = '1;
        if (active && (!cfg.ss || state == ST_STROBE))
            cs_n[act_cs] = 1'b0;
        oe_n = !((state == ST_STROBE) && !act_wr);
        we_n = !((state == ST_STROBE) && act_wr);
    end

    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    p_turn_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> (state == ST_TURN || state == ST_SETUP));

    p_ss_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ss && state != ST_STROBE) |-> (&cs_n));

    p_wait_extends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == '0 && wait_hit) |=> (state == ST_STROBE && cnt == '0));

    p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    p_accept_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/amc_datapath.sv
module amc_datapath #(
    parameter int OFS_W = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic [OFS_W-1:0]           req_ofs,
    input  logic [amc_pkg::DATA_W-1:0] req_wdata,
    input  logic [1:0]                 req_be,
    input  logic                       active,
    input  logic                       act_wr,
    input  logic                       capture,
    input  logic                       wide,
    input  logic                       oe_n,
    output logic [OFS_W-1:0]           mem_addr,
    output logic [1:0]                 mem_be_n,
    output logic [amc_pkg::DATA_W-1:0] rdata,
    inout  wire  [amc_pkg::DATA_W-1:0] mem_dq
);
    localparam int DW = amc_pkg::DATA_W;
    localparam int LW = amc_pkg::LANE_W;

    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    wdat_q;
    logic [1:0]       be_q;
    logic             dq_oe;
    logic [DW-1:0]    dq_o;
    logic [DW-1:0]    dq_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            wdat_q <= '0;
            be_q   <= '0;
        end else if (accept) begin
            ofs_q  <= req_ofs;
            wdat_q <= req_wdata;
            be_q   <= req_be;
        end
    end

    always_comb begin
        mem_addr = wide ? {1'b0, ofs_q[OFS_W-1:1]} : ofs_q;
        if (wide)
            mem_be_n = act_wr ? ~be_q : 2'b00;
        else
            mem_be_n = 2'b10;
        dq_oe = active && act_wr;
        dq_o  = wide ? wdat_q : {{(DW-LW){1'b0}}, wdat_q[LW-1:0]};
    end

    assign mem_dq = dq_oe ? dq_o : {DW{1'bz}};
    assign dq_in  = mem_dq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= wide ? dq_in : {{(DW-LW){1'b0}}, dq_in[LW-1:0]};
    end

    p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(mem_addr));

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
    parameter int NCS   = 4,
    parameter int OFS_W = 26
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [$clog2(NCS)+OFS_W-1:0]       req_addr,
    input  logic                               req_write,
    input  logic [amc_pkg::DATA_W-1:0]         req_wdata,
    input  logic [1:0]                         req_be,
    output logic                               rsp_valid,
    output logic [amc_pkg::DATA_W-1:0]         rsp_rdata,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_rd_setup,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_rd_strobe,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_rd_hold,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_wr_setup,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_wr_strobe,
    input  logic [NCS*amc_pkg::TIME_W-1:0]     cfg_wr_hold,
    input  logic [NCS*amc_pkg::GAP_W-1:0]      cfg_turn,
    input  logic [NCS-1:0]                     cfg_wide,
    input  logic [NCS-1:0]                     cfg_sel_strobe,
    input  logic [NCS-1:0]                     cfg_ext_wait,
    output logic [NCS-1:0]                     mem_cs_n,
    output logic                               mem_oe_n,
    output logic                               mem_we_n,
    output logic [OFS_W-1:0]                   mem_addr,
    output logic [1:0]                         mem_be_n,
    inout  wire  [amc_pkg::DATA_W-1:0]         mem_dq,
    input  logic [NCS-1:0]                     mem_wait
);
    localparam int CSW = $clog2(NCS);

    logic [CSW-1:0]   req_cs;
    logic [OFS_W-1:0] req_ofs;
    logic [CSW-1:0]   act_cs;
    logic [CSW-1:0]   sel_cs;
    logic             act_wr;
    logic             accept;
    logic             active;
    logic             capture;
    amc_pkg::cs_cfg_t cur_cfg;

    assign req_cs  = req_addr[CSW+OFS_W-1:OFS_W];
    assign req_ofs = req_addr[OFS_W-1:0];
    // while idle the timing of the incoming request is needed, else the active one
    assign sel_cs  = req_ready ? req_cs : act_cs;

    amc_cfg_mux #(.NCS(NCS)) u_cfg (
        .rd_setup  (cfg_rd_setup),
        .rd_strobe (cfg_rd_strobe),
        .rd_hold   (cfg_rd_hold),
        .wr_setup  (cfg_wr_setup),
        .wr_strobe (cfg_wr_strobe),
        .wr_hold   (cfg_wr_hold),
        .wide      (cfg_wide),
        .ss_mode   (cfg_sel_strobe),
        .ew_mode   (cfg_ext_wait),
        .sel       (sel_cs),
        .cfg       (cur_cfg)
    );

    amc_fsm #(.NCS(NCS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .cfg       (cur_cfg),
        .turn      (cfg_turn),
        .mem_wait  (mem_wait),
        .req_ready (req_ready),
        .accept    (accept),
        .active    (active),
        .capture   (capture),
        .rvalid    (rsp_valid),
        .act_wr    (act_wr),
        .act_cs    (act_cs),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n)
    );

    amc_datapath #(.OFS_W(OFS_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_ofs   (req_ofs),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .active    (active),
        .act_wr    (act_wr),
        .capture   (capture),
        .wide      (cur_cfg.wide),
        .oe_n      (mem_oe_n),
        .mem_addr  (mem_addr),
        .mem_be_n  (mem_be_n),
        .rdata     (rsp_rdata),
        .mem_dq    (mem_dq)
    );

endmodule

// File: tb/async_mem_ctrl_tb_top.sv
module async_mem_ctrl_tb_top;

    localparam int NCS   = 4;
    localparam int OFS_W = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] c_rs, c_rst, c_rh, c_ws, c_wst, c_wh;
    logic [11:0] c_turn;
    logic [3:0]  c_wide, c_ss, c_ew;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n;
    logic [25:0] mem_addr;
    logic [1:0]  mem_be_n;
    wire  [15:0] mem_dq;
    logic [3:0]  mem_wait = '0;
    logic        tb_drv = 1'b0;
    logic [15:0] tb_val = '0;

    int rs[4], rst[4], rh[4], ws[4], wst[4], wh[4], trn[4];
    bit wide[4], ss[4], ew[4];

    always #2.5 clk = ~clk;

    assign mem_dq = tb_drv ? tb_val : 16'bz;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            c_rs[i*4 +: 4]  = 4'(rs[i]);
            c_rst[i*4 +: 4] = 4'(rst[i]);
            c_rh[i*4 +: 4]  = 4'(rh[i]);
            c_ws[i*4 +: 4]  = 4'(ws[i]);
            c_wst[i*4 +: 4] = 4'(wst[i]);
            c_wh[i*4 +: 4]  = 4'(wh[i]);
            c_turn[i*3 +: 3] = 3'(trn[i]);
            c_wide[i] = wide[i];
            c_ss[i]   = ss[i];
            c_ew[i]   = ew[i];
        end
    end

    async_mem_ctrl #(.NCS(NCS), .OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_rd_setup(c_rs), .cfg_rd_strobe(c_rst), .cfg_rd_hold(c_rh),
        .cfg_wr_setup(c_ws), .cfg_wr_strobe(c_wst), .cfg_wr_hold(c_wh),
        .cfg_turn(c_turn), .cfg_wide(c_wide), .cfg_sel_strobe(c_ss), .cfg_ext_wait(c_ew),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dq(mem_dq), .mem_wait(mem_wait)
    );

    typedef struct {
        int cs; bit wr; int ofs; logic [15:0] data; logic [1:0] be;
        int idle; int wlen; bit ew3;
    } txn_t;

    typedef struct {
        logic [3:0] cs_n; logic oe_n, we_n, ready, rv;
        logic [15:0] rdata;
        bit active, wr, ss, wait_v, drv; int wcs;
        logic [15:0] drv_val, wdq; logic [25:0] addr; logic [1:0] be_n;
        string tag;
    } exp_t;

    txn_t txns[$];
    exp_t q[$];
    int total = 0, bad = 0;
    bit finished = 0;
    bit have_prev = 0; int pcs = 0; bit pwr = 0;
    bit pend_rv = 0; logic [15:0] pend_data = '0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic add(int cs, bit wr, int ofs, logic [15:0] d, logic [1:0] be,
                       int idle, int wlen, bit ew3);
        txn_t t;
        t.cs = cs; t.wr = wr; t.ofs = ofs; t.data = d; t.be = be;
        t.idle = idle; t.wlen = wlen; t.ew3 = ew3;
        txns.push_back(t);
    endtask

    function automatic exp_t idle_e(string tag);
        exp_t e;
        e.cs_n = 4'hF; e.oe_n = 1; e.we_n = 1; e.ready = 1; e.rv = 0; e.rdata = '0;
        e.active = 0; e.wr = 0; e.ss = 0; e.wait_v = 0; e.drv = 0; e.wcs = 0;
        e.drv_val = '0; e.wdq = '0; e.addr = '0; e.be_n = '0; e.tag = tag;
        return e;
    endfunction

    function automatic int atleast1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    // behavioural timeline of one access, pushed as one entry per clock
    task automatic build(txn_t t);
        int su, st, ho, tgap, n;
        string base;
        exp_t e;
        su = atleast1(t.wr ? ws[t.cs]  : rs[t.cs]);
        st = atleast1(t.wr ? wst[t.cs] : rst[t.cs]);
        ho = atleast1(t.wr ? wh[t.cs]  : rh[t.cs]);
        tgap = (have_prev && (t.cs != pcs || t.wr != pwr)) ? trn[pcs] : 0;
        n = (ew[t.cs] && t.wlen + 1 > st) ? t.wlen + 1 : st;
        base = t.wr ? "R3" : "R2";
        if (t.cs == 1) base = "R4";
        for (int i = 0; i < tgap; i++) begin
            e = idle_e("R5"); e.ready = 0; q.push_back(e);
        end
        for (int ph = 0; ph < 3; ph++) begin
            int len = (ph == 0) ? su : (ph == 1) ? n : ho;
            for (int k = 0; k < len; k++) begin
                e = idle_e(base);
                e.ready = 0; e.active = 1; e.wr = t.wr; e.ss = ss[t.cs]; e.wcs = t.cs;
                if (ph == 0 && k == 0 && have_prev && t.cs == pcs && t.wr == pwr) e.tag = "R6";
                if (ph == 1 && k >= st) e.tag = "R8";
                if (!ss[t.cs] || ph == 1) e.cs_n[t.cs] = 1'b0;
                if (ph == 1) begin
                    e.oe_n = t.wr; e.we_n = !t.wr;
                    e.wait_v = (k < t.wlen);
                    if (!t.wr) begin
                        e.drv = 1;
                        e.drv_val = (k == n - 1) ? t.data : ~t.data;
                    end
                end
                e.addr = wide[t.cs] ? 26'(t.ofs >> 1) : 26'(t.ofs);
                e.be_n = wide[t.cs] ? (t.wr ? ~t.be : 2'b00) : 2'b10;
                e.wdq  = wide[t.cs] ? t.data : {8'h00, t.data[7:0]};
                q.push_back(e);
            end
        end
        if (!t.wr) begin
            pend_rv = 1;
            pend_data = wide[t.cs] ? t.data : {8'h00, t.data[7:0]};
        end
        have_prev = 1; pcs = t.cs; pwr = t.wr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
        end
    end

    initial begin
        exp_t cur;
        int ti = 0, idle_left, tail = 0;
        // cs0 16-bit plain; cs1 all-zero widths 8-bit; cs2 select-strobe 16-bit; cs3 wait 8-bit
        rs  = '{2, 0, 1, 1}; rst = '{3, 0, 1, 2}; rh = '{1, 0, 2, 1};
        ws  = '{1, 0, 2, 1}; wst = '{2, 0, 1, 1}; wh = '{1, 0, 1, 1};
        trn = '{2, 0, 3, 1};
        wide = '{1, 0, 1, 0}; ss = '{0, 0, 1, 0}; ew = '{0, 0, 0, 1};

        add(0, 0, 'h0000100, 16'h1234, 2'b11, 0, 0, 1);
        add(0, 0, 'h0000102, 16'h5678, 2'b11, 0, 0, 1);  // R6 read after read
        add(0, 1, 'h0000104, 16'hCAFE, 2'b11, 0, 0, 1);  // R5 direction change
        add(0, 1, 'h0000106, 16'hBEEF, 2'b01, 0, 0, 1);  // R6 write after write
        add(1, 0, 'h0000011, 16'h77A5, 2'b11, 0, 0, 1);  // R4 zero widths, R9 8-bit
        add(1, 1, 'h0000013, 16'h9C3D, 2'b11, 0, 0, 1);
        add(2, 0, 'h2000040, 16'hA1B2, 2'b11, 1, 0, 1);  // R7
        add(2, 1, 'h2000042, 16'hD00D, 2'b10, 0, 0, 1);  // R9 byte enables
        add(3, 0, 'h1234567, 16'h4E5F, 2'b11, 0, 4, 1);  // R8 extension
        add(3, 1, 'h1234568, 16'h6061, 2'b11, 0, 0, 1);
        add(3, 0, 'h1234569, 16'h7273, 2'b11, 0, 1, 1);  // R8 short wait: no stretch
        add(2, 0, 'h0000080, 16'h8485, 2'b11, 3, 0, 1);  // R5 idle not credited
        add(3, 0, 'h00000AA, 16'h9697, 2'b11, 2, 5, 0);  // R8 mode off: wait ignored

        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11", "cs_n", 32'(mem_cs_n), 32'hF);
        chk("R11", "oe_n", 32'(mem_oe_n), 32'h1);
        chk("R11", "we_n", 32'(mem_we_n), 32'h1);
        chk("R11", "rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R11", "req_ready", 32'(req_ready), 32'h1);
        rst_n = 1'b1;

        idle_left = txns[0].idle;
        while (1) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (q.size() == 0) begin
                cur = idle_e("R12");
                cur.rv = pend_rv; cur.rdata = pend_data; pend_rv = 0;
                if (ti < txns.size()) begin
                    if (idle_left > 0) idle_left--;
                    else begin
                        txn_t t = txns[ti];
                        ew[3] = t.ew3;
                        req_valid = 1'b1; req_write = t.wr;
                        req_addr = {2'(t.cs), 26'(t.ofs)};
                        req_wdata = t.data; req_be = t.be;
                        build(t);
                        ti++;
                        if (ti < txns.size()) idle_left = txns[ti].idle;
                    end
                end else if (!pend_rv && !cur.rv) begin
                    tail++;
                    if (tail > 3) break;
                end
            end else begin
                cur = q.pop_front();
            end
            mem_wait = cur.wait_v ? 4'(1 << cur.wcs) : 4'h0;
            tb_drv = cur.drv; tb_val = cur.drv_val;
            #1;
            chk(cur.ss ? "R7" : "R1", "cs_n", 32'(mem_cs_n), 32'(cur.cs_n));
            chk(cur.tag, "oe_n", 32'(mem_oe_n), 32'(cur.oe_n));
            chk(cur.tag, "we_n", 32'(mem_we_n), 32'(cur.we_n));
            chk("R12", "req_ready", 32'(req_ready), 32'(cur.ready));
            chk("R10", "rsp_valid", 32'(rsp_valid), 32'(cur.rv));
            if (cur.rv) chk("R10", "rsp_rdata", 32'(rsp_rdata), 32'(cur.rdata));
            if (cur.active) begin
                chk("R9", "mem_addr", 32'(mem_addr), 32'(cur.addr));
                chk("R9", "mem_be_n", 32'(mem_be_n), 32'(cur.be_n));
                if (cur.wr) chk("R3", "mem_dq", 32'(mem_dq), 32'(cur.wdq));
            end
        end
        summary();
    end

endmodule